// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 28-pin general-purpose I/O controller on a simple 32-bit word-addressed register bus. Each pin has a direction bit and an output latch. The latch never takes a plain write. It is changed only through a set-strobe register and a clear-strobe register, so software can change one pin without a read-modify-write. A level register returns the synchronized value of every pin, whatever its direction.

Each pin has separate rising-edge and falling-edge enables. An enabled edge latches a bit in a sticky event register, and writing ones to that register clears the bits. Pins 0 to 10 each drive their own registered interrupt line. Pins 11 to 27 share a single line. An alternate-function select register is only stored and brought out for use elsewhere.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, direction, output latch, both edge enables, event status, alternate-function select and all interrupt outputs are 0.
- R2: A write to word offset 0x08 sets every latch bit that has a 1 in the written data and leaves the other bits unchanged. `pin_out` shows the latch from the next clock on.
- R3: A write to word offset 0x0C clears every latch bit that has a 1 in the written data and leaves the other bits unchanged.
- R4: Offset 0x04 holds the direction bits, where 1 means output, and drives `pin_oe`. Offset 0x00 returns `pin_in` after two flops, whatever the direction. Writes to offset 0x00 have no effect.
- R5: When rising detection is enabled for a pin (offset 0x10), a low-to-high change on that pin sets its event bit (offset 0x18). The change is first sampled at clock edge k, and the bit reads 1 after edge k+2.
- R6: Offset 0x14 enables falling-edge detection in the same way. A pin with both enables set records a change in either direction.
- R7: Event bits are sticky. A write to 0x18 clears the bits written as 1 and leaves the other bits set. Writing all ones clears every pending event.
- R8: If an enabled edge and a clear of the same event bit happen in the same cycle, the bit stays set.
- R9: A pin with both enables cleared latches no new events. A bit that is already set stays set until it is cleared by a write.
- R10: `irq_pin[i]` (i = 0..10) equals event bit i as it stood one clock earlier. `irq_shared` equals the OR of event bits 11 to 27 as they stood one clock earlier.
- R11: Read data is combinational from the register selected by `bus_addr[4:2]`. Bits 31:28 always read 0. Offsets 0x08 and 0x0C read 0. Offset 0x1C stores bits 27:0 and drives `alt_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| pin_in | input | 28 | Pin levels, asynchronous |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable, one per pin |
| alt_sel | output | 28 | Stored alternate-function select |
| irq_pin | output | 11 | Per-pin interrupts for pins 0..10 |
| irq_shared | output | 1 | Combined interrupt for pins 11..27 |

## Verification
The hardest case to reach is a write-one-to-clear that lands in exactly the cycle in which a new enabled edge reaches the event register. From the ports that cycle is two clock edges after the synchronizer first samples the pin change. To hit it, the bench first makes the bit pending, toggles the pin again, and then times the clear write to that edge. A reference model in the bench, clocked on every cycle, checks that the bit survives. The same model covers disabling the enables while a bit is pending. It also covers the shared interrupt staying high until the last of its seventeen bits is cleared.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NPINS   = 28,
  parameter int NDIRECT = 11,
  parameter int DW      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  alt_sel,
  output logic [NDIRECT-1:0] irq_pin,
  output logic              irq_shared
);
  localparam int PADW = DW - NPINS;
  localparam logic [2:0] A_LEVEL = 3'd0, A_DIR = 3'd1, A_SET = 3'd2, A_CLR = 3'd3,
                         A_REN = 3'd4, A_FEN = 3'd5, A_STAT = 3'd6, A_ALT = 3'd7;

  logic [NPINS-1:0] sync1, sync2, hist;
  logic [NPINS-1:0] dir_q, out_q, ren_q, fen_q, stat_q, alt_q;
  logic [NPINS-1:0] wd, hit, w1c;
  logic             wr;

  assign wr  = bus_sel & bus_wr;
  assign wd  = bus_wdata[NPINS-1:0];
  assign hit = (sync2 & ~hist & ren_q) | (~sync2 & hist & fen_q);
  assign w1c = (wr && bus_addr[4:2] == A_STAT) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      hist  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      hist  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      alt_q <= '0;
    end else if (wr) begin
      case (bus_addr[4:2])
        A_DIR:   dir_q <= wd;
        A_SET:   out_q <= out_q | wd;
        A_CLR:   out_q <= out_q & ~wd;
        A_REN:   ren_q <= wd;
        A_FEN:   fen_q <= wd;
        A_ALT:   alt_q <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      irq_pin    <= '0;
      irq_shared <= 1'b0;
    end else begin
      stat_q     <= (stat_q & ~w1c) | hit;
      irq_pin    <= stat_q[NDIRECT-1:0];
      irq_shared <= |stat_q[NPINS-1:NDIRECT];
    end
  end

  logic [NPINS-1:0] rd;
  always_comb begin
    case (bus_addr[4:2])
      A_LEVEL: rd = sync2;
      A_DIR:   rd = dir_q;
      A_REN:   rd = ren_q;
      A_FEN:   rd = fen_q;
      A_STAT:  rd = stat_q;
      A_ALT:   rd = alt_q;
      default: rd = '0;
    endcase
  end

  assign bus_rdata = {{PADW{1'b0}}, rd};
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign alt_sel   = alt_q;
endmodule

module gpio_edge_ctrl_chk #(
  parameter int NPINS   = 28,
  parameter int NDIRECT = 11,
  parameter int DW      = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [4:0]       bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] ren_q,
  input logic [NPINS-1:0] fen_q,
  input logic             irq_shared
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[4:2] == 3'd2) |=>
      ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[4:2] == 3'd3) |=>
      ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr[4:2] == 3'd6) |=>
      ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_no_event_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ren_q | fen_q)) == '0));

  p_shared_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_shared) |-> $past(|stat_q[NPINS-1:NDIRECT]));

  p_top_bits_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NPINS] == '0);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS), .NDIRECT(NDIRECT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .stat_q(stat_q),
  .ren_q(ren_q), .fen_q(fen_q), .irq_shared(irq_shared));

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h18;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [27:0] pin_in = '0;
  logic [27:0] pin_out, pin_oe, alt_sel;
  logic [10:0] irq_pin;
  logic        irq_shared;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .alt_sel(alt_sel), .irq_pin(irq_pin), .irq_shared(irq_shared));

  // reference model, written from the requirements
  logic [27:0] m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_stat, m_alt;
  logic [10:0] m_irqp;
  logic        m_irqs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_dir <= '0; m_out <= '0;
      m_ren <= '0; m_fen <= '0; m_stat <= '0; m_alt <= '0; m_irqp <= '0; m_irqs <= 1'b0;
    end else begin
      logic [27:0] ev, clr;
      ev  = 28'(m_s2 & ~m_prev & m_ren) | 28'(~m_s2 & m_prev & m_fen);
      clr = (bus_sel && bus_wr && bus_addr[4:2] == 3'd6) ? bus_wdata[27:0] : 28'd0;
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      m_stat <= (m_stat & ~clr) | ev;
      m_irqp <= m_stat[10:0];
      m_irqs <= (m_stat[27:11] != 0);
      if (bus_sel && bus_wr) begin
        case (bus_addr[4:2])
          3'd1: m_dir <= bus_wdata[27:0];
          3'd2: m_out <= m_out | bus_wdata[27:0];
          3'd3: m_out <= m_out & ~bus_wdata[27:0];
          3'd4: m_ren <= bus_wdata[27:0];
          3'd5: m_fen <= bus_wdata[27:0];
          3'd7: m_alt <= bus_wdata[27:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a[4:2])
      3'd0: return {4'h0, m_s2};
      3'd1: return {4'h0, m_dir};
      3'd4: return {4'h0, m_ren};
      3'd5: return {4'h0, m_fen};
      3'd6: return {4'h0, m_stat};
      3'd7: return {4'h0, m_alt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      vectors++;
      cmp("R1/R2/R3 pin_out", {4'h0, pin_out}, {4'h0, m_out});
      cmp("R4 pin_oe", {4'h0, pin_oe}, {4'h0, m_dir});
      cmp("R11 alt_sel", {4'h0, alt_sel}, {4'h0, m_alt});
      cmp("R10 irq_pin", {21'h0, irq_pin}, {21'h0, m_irqp});
      cmp("R10 irq_shared", {31'h0, irq_shared}, {31'h0, m_irqs});
      cmp("R4/R5/R6/R7/R11 bus_rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 5'h18;
  endtask

  task automatic look(input logic [4:0] a, input int n);
    @(negedge clk);
    bus_addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic [27:0] v, input int settle);
    @(negedge clk);
    pin_in = v;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state observed while reset is held and after release
    pin_in = 28'h0F0_F0F0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) look(5'(a * 4), 1);
    // R2 / R3: set and clear strobes
    wr(5'h08, 32'h0000_00FF);
    wr(5'h08, 32'hF000_1200);
    wr(5'h0C, 32'h0000_000F);
    wr(5'h0C, 32'h0000_0000);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h0555_5555);
    look(5'h08, 2);
    look(5'h0C, 2);
    // R4: direction and level, any direction; writes to level ignored
    wr(5'h04, 32'hFFFF_0000);
    pins(28'hABC_DEF1, 3);
    look(5'h00, 3);
    wr(5'h00, 32'h1234_5678);
    look(5'h00, 2);
    look(5'h04, 1);
    // R11: alternate-function register and high bits
    wr(5'h1C, 32'hFEDC_BA98);
    look(5'h1C, 2);
    pins(28'h0, 4);
    // R5: rising edges on pins 3 and 20
    wr(5'h10, 32'h0010_0008);
    pins(28'h010_0008, 5);
    pins(28'h0, 5);
    // R7: partial clear, then all ones
    wr(5'h18, 32'h0000_0008);
    look(5'h18, 2);
    wr(5'h18, 32'hFFFF_FFFF);
    look(5'h18, 2);
    // R6: falling edges on pin 20 and both edges on pin 5
    wr(5'h10, 32'h0000_0020);
    wr(5'h14, 32'h0010_0020);
    pins(28'h010_0020, 5);
    wr(5'h18, 32'hFFFF_FFFF);
    pins(28'h0, 5);
    wr(5'h18, 32'h0000_0020);
    look(5'h18, 3);
    // R10: shared line stays high until the last group bit clears
    wr(5'h10, 32'h0880_0000);
    pins(28'h880_0000, 5);
    wr(5'h18, 32'h0800_0000);
    look(5'h18, 3);
    wr(5'h18, 32'h0090_0000);
    look(5'h18, 3);
    // R8: edge and clear in the same cycle; pin 2 pending, then new edge
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0000_0004);
    wr(5'h14, 32'h0000_0004);
    pins(28'h000_0004, 5);
    @(negedge clk); pin_in = 28'h0;   // sampled at next edge k
    @(negedge clk);                   // edge k passed
    @(negedge clk);                   // edge k+1 passed, event pending in model
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h18; bus_wdata = 32'h0000_0004;
    @(negedge clk);                   // clear and new edge both at edge k+2
    bus_sel = 1'b0; bus_wr = 1'b0;
    look(5'h18, 3);
    // R9: disable enables; pending bit stays, no new events
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h0);
    pins(28'hFFF_FFFF, 5);
    pins(28'h0, 5);
    look(5'h18, 2);
    wr(5'h18, 32'h0000_0004);
    look(5'h18, 3);
    // mixed sweep across all pins with both edges enabled
    wr(5'h10, 32'h0FFF_FFFF);
    wr(5'h14, 32'h0FFF_FFFF);
    for (int i = 0; i < 12; i++) begin
      pins(28'((i * 32'h0135_7A1D) ^ (i << 9)), 4);
      wr(5'h18, 32'(32'h0F0F_0F0F >> i));
    end
    look(5'h18, 4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule